// File: doc/BRIEF.md
# Four-Level Leg Switch-State Encoder with Flying-Capacitor Balancing

This block controls one phase leg of a four-level nested clamped converter. Each clock it takes a requested output level from 0 to 3 and registers a leg state. From that state it drives the six gate signals of the leg. The outer levels 0 and 3 each have one switch pattern. The inner levels 1 and 2 each have two redundant patterns, called variants A and B, and both give the same output voltage.

The leg has two flying capacitors, an upper one and a lower one. Each has a target voltage of one third of the DC bus. The voltage error of a capacitor is its voltage minus that target. The block receives the sign of each error and the sign of the phase current. When balancing is enabled, the block uses these signs to pick the variant that moves the relevant capacitor toward its target:
- At level 2, the choice affects only the upper capacitor.
- At level 1, the choice affects only the lower capacitor.

When balancing is disabled, variant A is always used. The block is built as a small state machine with six named states: `ST_L0`, `ST_L1A`, `ST_L1B`, `ST_L2A`, `ST_L2B` and `ST_L3`. On every clock the machine may move from any state to any other. The target state follows from the level request and the sign inputs. Reset forces `ST_L0`.

Top module: `fourlvl_leg_encoder`

## Requirements
- R1: A level 3 request selects `ST_L3` (tag 5), with gates S1..S6 = 1,1,1,0,0,0 (gate_o = 6'b000111, bit 0 is S1). The sign and enable inputs have no effect.
- R2: A level 0 request selects `ST_L0` (tag 0), with gates S1..S6 = 0,0,0,1,1,1 (gate_o = 6'b111000). The sign and enable inputs have no effect.
- R3: With balancing on, a level 2 request selects `ST_L2B` (tag 4, gate_o = 6'b100110) when the upper-capacitor error sign equals the current sign. Here "negative" and "zero or positive" are the two classes compared. Otherwise it selects `ST_L2A` (tag 3, gate_o = 6'b001101).
- R4: With balancing on, a level 1 request selects `ST_L1B` (tag 2, gate_o = 6'b101100) when the lower-capacitor error sign equals the current sign. Otherwise it selects `ST_L1A` (tag 1, gate_o = 6'b011001).
- R5: The lower-capacitor error has no effect at level 2, and the upper-capacitor error has no effect at level 1.
- R6: With balancing off (bal_en = 0), level 2 always gives `ST_L2A` and level 1 always gives `ST_L1A`.
- R7: state_o reports the registered state with the tag encoding 0=L0, 1=L1A, 2=L1B, 3=L2A, 4=L2B, 5=L3. gate_o always matches the pattern of the state that state_o reports.
- R8: The outputs change exactly one rising clock edge after the inputs change. They hold their value between edges.
- R9: Asserting rst_n low forces state tag 0 and gate pattern 6'b111000 at once, without waiting for a clock edge.
- R10: Exactly three of the six gates are on at all times out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| level_req | input | 2 | Requested output level, 0 to 3 |
| c_up_err_neg | input | 1 | 1 when the upper flying-capacitor error is negative |
| c_lo_err_neg | input | 1 | 1 when the lower flying-capacitor error is negative |
| cur_neg | input | 1 | 1 when the phase current is negative |
| bal_en | input | 1 | Enables redundant-state balancing |
| gate_o | output | 6 | Gate drives; bit 0 is S1, bit 5 is S6 |
| state_o | output | 3 | Tag of the registered leg state |

## Verification
The bench walks all four sign combinations at each inner level. This catches a design that inverts one half of the selection rule, which would charge a capacitor that should be discharged. It drives the "wrong" capacitor's error sign at each inner level, so that a design reading the wrong error input shows the wrong variant. It also samples between the input change and the next edge, to catch a missing or extra register stage. It asserts reset in the middle of a run, so that a reset that is synchronous or that leaves the gates in another pattern shows up at once.

// File: rtl/fourlvl_leg_pkg.sv
package fourlvl_leg_pkg;

    localparam int LVL_W = 2;
    localparam int SW_N  = 6;
    localparam int ST_W  = 3;

    typedef enum logic [ST_W-1:0] {
        ST_L0  = 3'd0,
        ST_L1A = 3'd1,
        ST_L1B = 3'd2,
        ST_L2A = 3'd3,
        ST_L2B = 3'd4,
        ST_L3  = 3'd5
    } leg_state_e;

    // Gate patterns, bit 0 = S1 ... bit 5 = S6
    localparam logic [SW_N-1:0] PAT_L0  = 6'b111000;
    localparam logic [SW_N-1:0] PAT_L1A = 6'b011001;
    localparam logic [SW_N-1:0] PAT_L1B = 6'b101100;
    localparam logic [SW_N-1:0] PAT_L2A = 6'b001101;
    localparam logic [SW_N-1:0] PAT_L2B = 6'b100110;
    localparam logic [SW_N-1:0] PAT_L3  = 6'b000111;

    // Output level produced by a state, used by checking logic
    function automatic logic [LVL_W-1:0] state_level(input leg_state_e st);
        logic [LVL_W-1:0] lv;
        case (st)
            ST_L3:          lv = 2'd3;
            ST_L2A, ST_L2B: lv = 2'd2;
            ST_L1A, ST_L1B: lv = 2'd1;
            default:        lv = 2'd0;
        endcase
        return lv;
    endfunction

endpackage

// File: rtl/leg_state_select.sv
module leg_state_select
    import fourlvl_leg_pkg::*;
(
    input  logic [LVL_W-1:0] level_req,
    input  logic             c_up_err_neg,
    input  logic             c_lo_err_neg,
    input  logic             cur_neg,
    input  logic             bal_en,
    output leg_state_e       next_state
);

    // Variant B is picked when error sign and current sign agree.
    logic up_use_b;
    logic lo_use_b;

    always_comb begin
        up_use_b = bal_en & ~(c_up_err_neg ^ cur_neg);
        lo_use_b = bal_en & ~(c_lo_err_neg ^ cur_neg);
    end

    always_comb begin
        next_state = ST_L0;
        unique case (level_req)
            2'd3: next_state = ST_L3;
            2'd2: next_state = up_use_b ? ST_L2B : ST_L2A;
            2'd1: next_state = lo_use_b ? ST_L1B : ST_L1A;
            2'd0: next_state = ST_L0;
            default: next_state = ST_L0;
        endcase
    end

endmodule

// File: rtl/leg_gate_decode.sv
module leg_gate_decode
    import fourlvl_leg_pkg::*;
(
    input  leg_state_e      state,
    output logic [SW_N-1:0] gates
);

    always_comb begin
        gates = PAT_L0;
        unique case (state)
            ST_L0:   gates = PAT_L0;
            ST_L1A:  gates = PAT_L1A;
            ST_L1B:  gates = PAT_L1B;
            ST_L2A:  gates = PAT_L2A;
            ST_L2B:  gates = PAT_L2B;
            ST_L3:   gates = PAT_L3;
            default: gates = PAT_L0;
        endcase
    end

endmodule

// File: rtl/fourlvl_leg_encoder.sv
module fourlvl_leg_encoder
    import fourlvl_leg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level_req,
    input  logic             c_up_err_neg,
    input  logic             c_lo_err_neg,
    input  logic             cur_neg,
    input  logic             bal_en,
    output logic [SW_N-1:0]  gate_o,
    output logic [ST_W-1:0]  state_o
);

    leg_state_e      state_q;
    leg_state_e      state_d;
    logic [SW_N-1:0] gates_d;

    leg_state_select u_sel (
        .level_req    (level_req),
        .c_up_err_neg (c_up_err_neg),
        .c_lo_err_neg (c_lo_err_neg),
        .cur_neg      (cur_neg),
        .bal_en       (bal_en),
        .next_state   (state_d)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_L0;
        else        state_q <= state_d;
    end

    leg_gate_decode u_dec (
        .state (state_q),
        .gates (gates_d)
    );

    // Output process
    always_comb begin
        gate_o  = gates_d;
        state_o = state_q;
    end

    // Assertions
    AST_RESET_LEVEL0: assert property (@(posedge clk) !rst_n |=> (state_o == 3'd0 && gate_o == 6'b111000)); // R9
    AST_ONE_CYCLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (state_level(leg_state_e'(state_o)) == $past(level_req))); // R8
    AST_THREE_GATES_ON: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gate_o) == 3); // R10
    AST_BAL_OFF_UPPER_A: assert property (@(posedge clk) disable iff (!rst_n)
        (!bal_en && level_req == 2'd2) |=> state_o == 3'd3); // R6
    AST_BAL_OFF_LOWER_A: assert property (@(posedge clk) disable iff (!rst_n)
        (!bal_en && level_req == 2'd1) |=> state_o == 3'd1); // R6
    AST_UPPER_NEG_NEG_B: assert property (@(posedge clk) disable iff (!rst_n)
        (bal_en && level_req == 2'd2 && c_up_err_neg && cur_neg) |=> gate_o == 6'b100110); // R3
    AST_UPPER_NEG_POS_A: assert property (@(posedge clk) disable iff (!rst_n)
        (bal_en && level_req == 2'd2 && c_up_err_neg && !cur_neg) |=> gate_o == 6'b001101); // R3
    AST_LOWER_POS_NEG_A: assert property (@(posedge clk) disable iff (!rst_n)
        (bal_en && level_req == 2'd1 && !c_lo_err_neg && cur_neg) |=> gate_o == 6'b011001); // R4
    AST_LOWER_POS_POS_B: assert property (@(posedge clk) disable iff (!rst_n)
        (bal_en && level_req == 2'd1 && !c_lo_err_neg && !cur_neg) |=> gate_o == 6'b101100); // R4
    AST_OUTER_LEVEL3: assert property (@(posedge clk) disable iff (!rst_n)
        (level_req == 2'd3) |=> gate_o == 6'b000111); // R1

endmodule

// File: tb/fourlvl_leg_encoder_tb_top.sv
module fourlvl_leg_encoder_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] level_req = 2'd0;
    logic       c_up_err_neg = 1'b0;
    logic       c_lo_err_neg = 1'b0;
    logic       cur_neg = 1'b0;
    logic       bal_en = 1'b0;
    logic [5:0] gate_o;
    logic [2:0] state_o;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    fourlvl_leg_encoder dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .level_req    (level_req),
        .c_up_err_neg (c_up_err_neg),
        .c_lo_err_neg (c_lo_err_neg),
        .cur_neg      (cur_neg),
        .bal_en       (bal_en),
        .gate_o       (gate_o),
        .state_o      (state_o)
    );

    // {cross[15], lvl[14:13], up_neg[12], lo_neg[11], cur_neg[10], bal[9], tag[8:6], gates[5:0]}
    localparam int NV = 21;
    localparam logic [15:0] VEC [NV] = '{
        {1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 3'd5, 6'b000111}, // R1
        {1'b0, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 3'd5, 6'b000111}, // R1
        {1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 3'd0, 6'b111000}, // R2
        {1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 3'd4, 6'b100110}, // R3
        {1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 3'd3, 6'b001101}, // R3
        {1'b0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 3'd3, 6'b001101}, // R3
        {1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 3'd4, 6'b100110}, // R3
        {1'b1, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 3'd4, 6'b100110}, // R5
        {1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 3'd4, 6'b100110}, // R5
        {1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 3'd2, 6'b101100}, // R4
        {1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 3'd1, 6'b011001}, // R4
        {1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1, 6'b011001}, // R4
        {1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd2, 6'b101100}, // R4
        {1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 3'd2, 6'b101100}, // R5
        {1'b1, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 3'd2, 6'b101100}, // R5
        {1'b0, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 3'd3, 6'b001101}, // R6
        {1'b0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 6'b001101}, // R6
        {1'b0, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 3'd1, 6'b011001}, // R6
        {1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1, 6'b011001}, // R6
        {1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 6'b111000}, // R2
        {1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 3'd5, 6'b000111}  // R1
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string vec_req(input logic [15:0] v);
        if (v[15])                  return "R5";
        if (v[14:13] == 2'd3)       return "R1";
        if (v[14:13] == 2'd0)       return "R2";
        if (!v[9])                  return "R6";
        if (v[14:13] == 2'd2)       return "R3";
        return "R4";
    endfunction

    task automatic apply(input logic [15:0] v);
        level_req    = v[14:13];
        c_up_err_neg = v[12];
        c_lo_err_neg = v[11];
        cur_neg      = v[10];
        bal_en       = v[9];
    endtask

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // Reset state, R9
        level_req = 2'd3;
        @(negedge clk);
        chk("R9 reset tag", {5'd0, state_o}, 8'd0);
        chk("R9 reset gates", {2'd0, gate_o}, 8'b00111000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1..R7, R10
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            @(negedge clk);
            chk({vec_req(VEC[i]), " R7 tag"}, {5'd0, state_o}, {5'd0, VEC[i][8:6]});
            chk({vec_req(VEC[i]), " gates"}, {2'd0, gate_o}, {2'd0, VEC[i][5:0]});
            chk("R10 three gates on", 8'($countones(gate_o)), 8'd3);
        end

        // Latency, R8: outputs hold until the next rising edge
        apply(VEC[19]); // level 0
        @(negedge clk);
        apply(VEC[3]);  // level 2 -> L2B
        #2;
        chk("R8 hold before edge", {2'd0, gate_o}, 8'b00111000);
        @(posedge clk);
        #2;
        chk("R8 update after edge", {2'd0, gate_o}, 8'b00100110);
        chk("R8 tag after edge", {5'd0, state_o}, 8'd4);

        // Mid-run async reset, R9
        @(negedge clk);
        #3;
        rst_n = 1'b0;
        #1;
        chk("R9 async reset tag", {5'd0, state_o}, 8'd0);
        chk("R9 async reset gates", {2'd0, gate_o}, 8'b00111000);
        @(negedge clk);
        chk("R9 held in reset", {2'd0, gate_o}, 8'b00111000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 after reset release", {5'd0, state_o}, 8'd4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule